// File: doc/BRIEF.md
# Four-Step Accumulator Processor

This block is a small 8-bit processor built around a single accumulator and one shared 16-byte memory that holds both program and data. Each instruction byte carries an operation code in its upper nibble and a memory address in its lower nibble. Every instruction passes through the same fixed register-transfer sequence:

1. The program counter is copied into the memory address register.
2. The addressed byte is captured in the memory data register.
3. That byte moves into the instruction register, and its address field is placed into the memory address register.
4. The operand byte is read and the operation is carried out.

Before a program runs, the memory is filled through a write stream that is accepted only while reset is held. When reset is released, execution starts at address 0. A surrounding environment watches progress through a halt flag and debug copies of the accumulator, program counter and carry flag. By convention, the lower eight addresses hold code and the upper eight hold data, but the hardware does not enforce this.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, accumulator, carry and `halted` clear to 0 and the sequencer returns to its first step. Memory contents are kept across reset.
- R2: `prog_ready` equals `rst`. A byte is written to memory at `prog_addr` on a rising edge where `prog_valid` and `prog_ready` are both high. `prog_valid` while `prog_ready` is low has no effect.
- R3: An instruction byte holds the opcode in bits [7:4] and the operand address in bits [3:0]. The first instruction is fetched from address 0. Every instruction other than one that halts occupies exactly four clock cycles.
- R4: The PC increases by one, modulo 16, on the second rising edge of each instruction.
- R5: Opcode 0001 (load) copies memory at the operand address into the accumulator.
- R6: Opcode 0010 (add) sets the accumulator to accumulator plus memory at the operand address, modulo 256. The carry flag takes bit 8 of the sum.
- R7: Opcode 0011 (store) writes the accumulator to memory at the operand address and leaves the accumulator unchanged.
- R8: Opcode 0100 (jump) loads the PC with the operand address.
- R9: Opcode 1111 (halt) raises `halted` on the fourth rising edge of that instruction. From then until reset, the PC (left at the halt address plus one), the accumulator and the carry do not change.
- R10: Every other opcode (0000 and 0101 through 1110) changes nothing except advancing the PC.
- R11: The carry flag changes only on an add.
- R12: A load or add result appears in the accumulator on the fourth rising edge of its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the preload stream |
| prog_valid | input | 1 | Preload byte offered |
| prog_ready | output | 1 | Preload byte can be accepted (high during reset) |
| prog_addr | input | 4 | Preload memory address |
| prog_data | input | 8 | Preload memory byte |
| halted | output | 1 | Processor has executed a halt |
| dbg_acc | output | 8 | Accumulator contents |
| dbg_pc | output | 4 | Program counter contents |
| dbg_carry | output | 1 | Carry flag from the last add |

## Verification
A wrong step in the sequencer or a misrouted MAR/MDR transfer shows up at the ports as a wrong final accumulator or PC value, or as a halt arriving a multiple of four cycles too early or too late. Because of that, each program is checked both for its end state and for the exact cycle at which `halted` rises. A PC increment on the wrong step, or an accumulator written a cycle early, would be invisible in the end state. It is caught within the first instruction by sampling `dbg_pc` and `dbg_acc` after every edge. A faulty store appears only once the stored byte is loaded back, so the programs read their stored results again.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OPC_LOAD  = 4'b0001;
  localparam logic [3:0] OPC_ADD   = 4'b0010;
  localparam logic [3:0] OPC_STORE = 4'b0011;
  localparam logic [3:0] OPC_JUMP  = 4'b0100;
  localparam logic [3:0] OPC_HALT  = 4'b1111;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR = 3'd0,
    ST_FETCH_DATA = 3'd1,
    ST_OPER_ADDR  = 3'd2,
    ST_EXECUTE    = 3'd3,
    ST_STOPPED    = 3'd4
  } step_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && waddr == ADDR_W'(g)) cells[g] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, lhs} + {1'b0, rhs};
    sum  = wide[DATA_W-1:0];
    cout = wide[DATA_W];
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  is_halt,
  output step_e step,
  output logic  halted
);
  step_e step_nx;

  always_comb begin
    step_nx = step;
    unique case (step)
      ST_FETCH_ADDR: step_nx = ST_FETCH_DATA;
      ST_FETCH_DATA: step_nx = ST_OPER_ADDR;
      ST_OPER_ADDR:  step_nx = ST_EXECUTE;
      ST_EXECUTE:    step_nx = is_halt ? ST_STOPPED : ST_FETCH_ADDR;
      ST_STOPPED:    step_nx = ST_STOPPED;
      default:       step_nx = ST_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_FETCH_ADDR;
      halted <= 1'b0;
    end else begin
      step <= step_nx;
      if (step == ST_EXECUTE && is_halt) halted <= 1'b1;
    end
  end

  // R3: a non-halting execute step always returns to the fetch step
  assert_four_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXECUTE && !is_halt) |=> step == ST_FETCH_ADDR);

  // R9: halt executes into the stopped state with the flag raised
  assert_halt_enter_R9: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXECUTE && is_halt) |=> (halted && step == ST_STOPPED));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic              halted,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic              dbg_carry
);
  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, ir, acc;
  logic              carry;
  logic [DATA_W-1:0] mem_rdata, alu_sum;
  logic              alu_cout;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] opnd;
  logic              is_load, is_add, is_store, is_jump, is_halt;
  logic              cpu_we, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  step_e             step;

  assign op   = ir[DATA_W-1 -: OP_W];
  assign opnd = ir[ADDR_W-1:0];

  always_comb begin
    is_load  = (op == OP_W'(OPC_LOAD));
    is_add   = (op == OP_W'(OPC_ADD));
    is_store = (op == OP_W'(OPC_STORE));
    is_jump  = (op == OP_W'(OPC_JUMP));
    is_halt  = (op == OP_W'(OPC_HALT));
  end

  assign prog_ready = rst;
  assign cpu_we     = !rst && step == ST_EXECUTE && is_store;

  always_comb begin
    if (rst) begin
      mem_we    = prog_valid;
      mem_waddr = prog_addr;
      mem_wdata = prog_data;
    end else begin
      mem_we    = cpu_we;
      mem_waddr = mar;
      mem_wdata = acc;
    end
  end

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (mem_rdata)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .lhs  (acc),
    .rhs  (mem_rdata),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  acc_cpu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .is_halt (is_halt),
    .step    (step),
    .halted  (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir    <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      unique case (step)
        ST_FETCH_ADDR: mar <= pc;
        ST_FETCH_DATA: begin
          mdr <= mem_rdata;
          pc  <= pc + 1'b1;
        end
        ST_OPER_ADDR: begin
          ir  <= mdr;
          mar <= mdr[ADDR_W-1:0];
        end
        ST_EXECUTE: begin
          mdr <= mem_rdata;
          if (is_load) acc <= mem_rdata;
          if (is_add) begin
            acc   <= alu_sum;
            carry <= alu_cout;
          end
          if (is_jump) pc <= opnd;
        end
        default: ;
      endcase
    end
  end

  assign dbg_acc   = acc;
  assign dbg_pc    = pc;
  assign dbg_carry = carry;

  // R4: second step advances the program counter by one
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH_DATA) |=> pc == ADDR_W'($past(pc) + 1'b1));

  // R7: a store never disturbs the accumulator
  assert_store_keeps_acc_R7: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXECUTE && is_store) |=> $stable(acc));

  // R9: once halted, architectural state is frozen
  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(carry)));

  // R11: carry is untouched outside an add
  assert_carry_only_add_R11: assert property (@(posedge clk) disable iff (rst)
    !(step == ST_EXECUTE && is_add) |=> $stable(carry));

  // R12: accumulator changes only at the execute step
  assert_acc_exec_R12: assert property (@(posedge clk) disable iff (rst)
    (step != ST_EXECUTE) |=> $stable(acc));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_valid = 1'b0;
  logic       prog_ready;
  logic [3:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic       halted;
  logic [7:0] dbg_acc;
  logic [3:0] dbg_pc;
  logic       dbg_carry;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .halted(halted),
    .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .dbg_carry(dbg_carry)
  );

  typedef struct packed {
    logic [127:0] img;   // byte i = memory address i
    logic [7:0]   acc;
    logic [3:0]   pc;
    logic         carry;
    logic [7:0]   cyc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // load 8, add 9, store A, load A, halt: 2+3
    '{128'h00000000000003020000_00F01A3A2918, 8'h05, 4'h5, 1'b0, 8'd20},
    // add with carry out: F0+20
    '{128'h000000000000_20F0_0000000000F02918, 8'h10, 4'h3, 1'b1, 8'd12},
    // nop, jump 5, load 8, halt
    '{128'h00000000000000770_0F01800_00F04500, 8'h77, 4'h7, 1'b0, 8'd16},
    // unassigned opcodes 5 and E act as nop
    '{128'h000000000000AA00_00000000F019E958, 8'hAA, 4'h4, 1'b0, 8'd16},
    // carry set then cleared by next add
    '{128'h00000000000501FF_00000000F02A2918, 8'h05, 4'h4, 1'b0, 8'd16},
    // load keeps carry
    '{128'h0000000000338080_00000000F01A2918, 8'h33, 4'h4, 1'b1, 8'd16}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2ns;
  endtask

  // Holds reset, writes all 16 bytes, leaves reset asserted.
  task automatic preload(input logic [127:0] img);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      prog_valid = 1'b1;
      prog_addr  = 4'(i);
      prog_data  = img[i*8 +: 8];
      tick(1);
    end
    prog_valid = 1'b0;
  endtask

  task automatic run_to_halt(output int cyc);
    rst = 1'b0;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      cyc++;
      if (halted) break;
    end
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    tick(2);

    // Table of programs
    for (int v = 0; v < NV; v++) begin
      preload(VECS[v].img);
      check("R1 acc in reset", 32'(dbg_acc), 32'h0);
      check("R1 pc in reset", 32'(dbg_pc), 32'h0);
      check("R2 ready in reset", 32'(prog_ready), 32'h1);
      run_to_halt(cyc);
      check("R3/R9 halt cycle", 32'(cyc), 32'(VECS[v].cyc));
      check("R5/R6/R7/R8/R10 acc", 32'(dbg_acc), 32'(VECS[v].acc));
      check("R4/R8/R9 pc", 32'(dbg_pc), 32'(VECS[v].pc));
      check("R6/R11 carry", 32'(dbg_carry), 32'(VECS[v].carry));
    end

    // R4 and R12: per-edge timing of the first instruction (load 8 = 02)
    preload(VECS[0].img);
    check("R1 halted cleared", 32'(halted), 32'h0);
    check("R1 carry cleared", 32'(dbg_carry), 32'h0);
    rst = 1'b0;
    tick(1);
    check("R4 pc after edge 1", 32'(dbg_pc), 32'h0);
    tick(1);
    check("R4 pc after edge 2", 32'(dbg_pc), 32'h1);
    check("R2 ready low when running", 32'(prog_ready), 32'h0);
    tick(1);
    check("R12 acc after edge 3", 32'(dbg_acc), 32'h0);
    tick(1);
    check("R12 acc after edge 4", 32'(dbg_acc), 32'h2);
    check("R3 pc after first instruction", 32'(dbg_pc), 32'h1);

    // R9: frozen after halt, and preload attempt ignored while running (R2)
    for (int i = 0; i < 200 && !halted; i++) tick(1);
    prog_valid = 1'b1;
    prog_addr  = 4'h8;
    prog_data  = 8'h40;
    tick(20);
    prog_valid = 1'b0;
    check("R9 halted held", 32'(halted), 32'h1);
    check("R9 pc frozen", 32'(dbg_pc), 32'h5);
    check("R9 acc frozen", 32'(dbg_acc), 32'h05);

    // R1: reset keeps memory; rerun without preload gives the same result
    rst = 1'b1;
    tick(2);
    check("R1 halted cleared by reset", 32'(halted), 32'h0);
    run_to_halt(cyc);
    check("R2 ignored write had no effect", 32'(dbg_acc), 32'h05);
    check("R1 memory retained cycles", 32'(cyc), 32'd20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule